// File: doc/BRIEF.md
# 4B5B Transmit Symbol Encoder

This block sits on the transmit side of a 100 Mb/s twisted-pair physical layer, between the nibble-wide media-independent data path and the scrambler. Each 25 MHz cycle it takes one 4-bit nibble and a transmit-enable strobe, and it produces one 5-bit code group. All sixteen nibble values map onto code groups that carry enough transitions for clock recovery, at a cost of one extra bit per nibble.

The block also frames the stream. While no frame is in progress it sends the all-ones idle group. When a frame starts, the first two preamble nibbles are replaced by the start-of-stream control pair J, K. The rest of the preamble, the start delimiter and the payload are then encoded as data. When enable drops, the block appends the end-of-stream pair T, R and then returns to idle. Control groups use patterns that no data nibble can produce, so a receiver can never mistake data for control or control for data.

Top module: `tx_4b5b_enc`

## Requirements
- R1: While rst_ni is low, and after reset until a frame starts, code_o is the idle group 5'b11111.
- R2: code_o is registered: it reflects the inputs sampled at the previous rising clock edge. Bit 4 of code_o is the first bit sent on the wire.
- R3: When tx_en_i is sampled high while the block is idle, the next two code groups are J = 5'b11000 and then K = 5'b10001. These two groups replace the first two nibbles of the frame, and the values of those two nibbles are discarded.
- R4: From the third nibble of a frame onward, each sampled nibble is sent as its data group. The table is: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R5: When tx_en_i is sampled low after the K group or after a data group, the next group is T = 5'b01101. The group after that is R = 5'b00111, and idle follows unless a new frame starts.
- R6: K always follows J, whatever tx_en_i does. If enable has already dropped, T follows that K.
- R7: While T is being sent, tx_en_i and txd_i are ignored. While R is being sent, tx_en_i sampled high starts a new frame, so J follows R directly.
- R8: A group sent in a data slot is never one of the J, K, T, R or idle patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 25 MHz nibble clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable, high for every nibble of a frame |
| txd_i | input | 4 | Transmit nibble |
| code_o | output | 5 | Code group, bit 4 sent first |

## Verification
The bench sends frames that step through all sixteen nibble values, so any wrong entry in the data table shows up. It also sends realistic preamble-and-delimiter frames, which show whether the J/K substitution swallows exactly two nibbles. Frames of one and two nibbles test the forced K and a T that follows K directly. Gaps of one, two and several idle cycles between frames separate three cases: a restart ignored during T, a restart taken during R, and a normal return to idle. A one-cycle reset pulse in the middle of a frame checks that the block recovers to idle.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_J, ST_K, ST_DATA, ST_T, ST_R
  } tx_st_e;

  localparam logic [CODE_W-1:0] C_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] C_J    = 5'b11000;
  localparam logic [CODE_W-1:0] C_K    = 5'b10001;
  localparam logic [CODE_W-1:0] C_T    = 5'b01101;
  localparam logic [CODE_W-1:0] C_R    = 5'b00111;

  function automatic logic [CODE_W-1:0] data_code(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: data_code = 5'b11110;
      4'h1: data_code = 5'b01001;
      4'h2: data_code = 5'b10100;
      4'h3: data_code = 5'b10101;
      4'h4: data_code = 5'b01010;
      4'h5: data_code = 5'b01011;
      4'h6: data_code = 5'b01110;
      4'h7: data_code = 5'b01111;
      4'h8: data_code = 5'b10010;
      4'h9: data_code = 5'b10011;
      4'hA: data_code = 5'b10110;
      4'hB: data_code = 5'b10111;
      4'hC: data_code = 5'b11010;
      4'hD: data_code = 5'b11011;
      4'hE: data_code = 5'b11100;
      default: data_code = 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/tx4b5b_fsm.sv
module tx4b5b_fsm
  import tx4b5b_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tx_en_i,
  output tx_st_e st_o
);
  tx_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = tx_en_i ? ST_J : ST_IDLE;
      ST_J:    st_d = ST_K;  // K is never cut short
      ST_K,
      ST_DATA: st_d = tx_en_i ? ST_DATA : ST_T;
      ST_T:    st_d = ST_R;
      ST_R:    st_d = tx_en_i ? ST_J : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  assign st_o = st_q;

  p_j_then_k_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_J) |=> (st_q == ST_K));
  p_t_then_r_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T) |=> (st_q == ST_R));
endmodule

// File: rtl/tx4b5b_map.sv
module tx4b5b_map
  import tx4b5b_pkg::*;
(
  input  tx_st_e            st_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    unique case (st_i)
      ST_J:    code_o = C_J;
      ST_K:    code_o = C_K;
      ST_DATA: code_o = data_code(nib_i);
      ST_T:    code_o = C_T;
      ST_R:    code_o = C_R;
      default: code_o = C_IDLE;
    endcase
  end

  p_data_not_ctrl_r8: assert final ((st_i != ST_DATA) ||
    ((code_o != C_J) && (code_o != C_K) && (code_o != C_T) &&
     (code_o != C_R) && (code_o != C_IDLE)));
endmodule

// File: rtl/tx_4b5b_enc.sv
module tx_4b5b_enc
  import tx4b5b_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [NIB_W-1:0]  txd_i,
  output logic [CODE_W-1:0] code_o
);
  tx_st_e            st;
  logic [NIB_W-1:0]  nib_q;

  tx4b5b_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tx_en_i(tx_en_i),
    .st_o   (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) nib_q <= '0;
    else         nib_q <= txd_i;

  tx4b5b_map u_map (
    .st_i  (st),
    .nib_i (nib_q),
    .code_o(code_o)
  );

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == C_IDLE && tx_en_i) |=> (code_o == C_J));
  p_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((code_o != C_IDLE && code_o != C_J && code_o != C_T && code_o != C_R)
      && !tx_en_i) |=> (code_o == C_T));
  p_idle_stays_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == C_IDLE && !tx_en_i) |=> (code_o == C_IDLE));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == C_R && tx_en_i) |=> (code_o == C_J));
endmodule

// File: tb/tx_4b5b_enc_tb_top.sv
module tx_4b5b_enc_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0;
  logic [3:0] txd = 0;
  logic [4:0] code;

  int checks = 0, errors = 0, cyc = 0;
  int m_st = 0;          // 0 idle 1 J 2 K 3 data 4 T 5 R
  logic [3:0] m_nib = 0;
  bit done = 0;

  logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};

  tx_4b5b_enc dut_i (.clk_i(clk), .rst_ni(rst_n), .tx_en_i(en), .txd_i(txd), .code_o(code));

  always #4 clk = ~clk;

  // reference: next-slot behaviour from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_st <= 0;
    else begin
      m_nib <= txd;
      case (m_st)
        0: m_st <= en ? 1 : 0;
        1: m_st <= 2;
        2, 3: m_st <= en ? 3 : 4;
        4: m_st <= 5;
        default: m_st <= en ? 1 : 0;
      endcase
    end
  end

  function automatic logic [4:0] exp_code();
    case (m_st)
      1: return 5'b11000;
      2: return 5'b10001;
      3: return tbl[m_nib];
      4: return 5'b01101;
      5: return 5'b00111;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic string req_of();
    case (m_st)
      1, 2: return "R3/R6";
      3: return "R4/R8";
      4, 5: return "R5/R7";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      checks++;
      if (code !== exp_code()) begin
        errors++;
        $display("FAIL %s (R2 timing) cyc %0d: code_o=%b expected %b", req_of(), cyc, code, exp_code());
      end
      if (m_st == 3) begin
        checks++;
        if (code inside {5'b11000, 5'b10001, 5'b01101, 5'b00111, 5'b11111}) begin
          errors++;
          $display("FAIL R8: data slot code_o=%b expected a data group %b", code, tbl[m_nib]);
        end
      end
    end
  end

  task automatic gap(int n);
    en = 0; txd = 4'h0;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_seq(int len, int start);
    for (int i = 0; i < len; i++) begin
      en = 1; txd = 4'((start + i) & 15);
      @(negedge clk);
    end
  endtask

  task automatic frame_pre(int payload);
    for (int i = 0; i < 15; i++) begin
      en = 1; txd = 4'h5; @(negedge clk);
    end
    en = 1; txd = 4'hD; @(negedge clk);
    for (int i = 0; i < payload; i++) begin
      en = 1; txd = 4'((i * 7 + 3) & 15); @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (code !== 5'b11111) begin
      errors++;
      $display("FAIL R1: reset code_o=%b expected 11111", code);
    end
    rst_n = 1;
    gap(4);
    frame_seq(40, 0);   gap(5);   // R4: full table
    frame_pre(20);      gap(3);
    frame_seq(1, 9);    gap(4);   // R6: J, K, T
    frame_seq(2, 4);    gap(4);   // R5: K then T
    frame_seq(6, 10);   gap(2);   // R7: restart in R slot
    frame_seq(6, 1);    gap(1);   // R7: enable during T ignored
    frame_seq(8, 12);   gap(3);
    frame_seq(5, 7);
    rst_n = 0; @(negedge clk);    // R1: reset mid-frame
    rst_n = 1;
    gap(3);
    frame_pre(12);      gap(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule